// File: doc/BRIEF.md
# Burst-of-Four Late-Write DDR SRAM Port

This block is the write side of a quad-data-rate style synchronous SRAM whose read and write ports run independently. A write command is taken on a rising edge of the clock (K) when the active-low write select is low, and the burst address is latched on that edge. Four data words follow, late, on the next rising edge, the falling edge after it (K#), the rising edge after that and the last falling edge. Each word arrives with active-low enables for its 9-bit lanes, and the four words land at four consecutive array words whose two low address bits count 0 to 3 in beat order.

The complementary clock is modelled as the falling edge of one clock `clk_i`. Words from rising edges go into an even holding register and words from falling edges into an odd one. Each rising edge moves a complete even/odd pair into the register-file array. A small burst read port returns four consecutive words, one per rising edge, so the array can be observed. A write command can be issued on every second rising edge, which keeps data moving on every edge. Each command's address travels down its own pipeline, so a burst still in flight is never disturbed by the next command.

The word width `DATA_W` is 36 (four lanes) or 18 (two lanes). `ADDR_W` sets the number of array words.

Top module: `qdr_b4_sram`

## Requirements
- R1: A write command is accepted at a rising edge where `wr_n_i` is 0 and no command was accepted at the rising edge just before. `wr_addr_i` is latched as the burst address on that edge.
- R2: For a command accepted at rising edge c, beat 0 is sampled at rising edge c+1, beat 1 at the falling edge after it, beat 2 at rising edge c+2 and beat 3 at the falling edge after that. Beat i is written to word address {burst address, i}, with i in the two low bits.
- R3: `wr_be_n_i` is sampled on the same edge as its data beat. Bit j at 0 writes bits 9j+8:9j of that beat. A lane whose bit is 1 keeps its old content.
- R4: `wr_n_i` at 0 on the rising edge right after an accepted command is ignored. No burst starts at that address, and the earlier burst is written intact.
- R5: Commands on every second rising edge run gapless, with a data beat on every edge, and each burst lands complete at its own address.
- R6: Data and lane enables presented on edges that carry no beat of an accepted burst leave the array unchanged.
- R7: Raising `wr_n_i` after a command does not cut the burst short. All four beats are still written.
- R8: Beats 0 and 1 are in the array from rising edge c+2 onward and beats 2 and 3 from rising edge c+3 onward. A read accepted at edge c+3 returns all four new words.
- R9: A read is accepted at a rising edge where `rd_n_i` is 0 and the read port is idle or is giving out its fourth word. Words {`rd_addr_i`, 0..3} then appear on `rd_data_o` on the next four rising edges with `rd_vld_o` at 1. Read requests during the first three words are ignored.
- R10: Reads and writes proceed at the same time without affecting each other's timing or results.
- R11: During and right after reset, `rd_vld_o` is 0 and no write is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; rising edge is K, falling edge is K# |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_n_i | input | 1 | Write select, active low, sampled on rising edge |
| wr_addr_i | input | ADDR_W-2 | Write burst address |
| wr_data_i | input | DATA_W | Write data, sampled on both edges during a burst |
| wr_be_n_i | input | DATA_W/9 | Active-low 9-bit lane write enables, sampled with data |
| rd_n_i | input | 1 | Read select, active low, sampled on rising edge |
| rd_addr_i | input | ADDR_W-2 | Read burst address |
| rd_data_o | output | DATA_W | Read word |
| rd_vld_o | output | 1 | Read word valid |

## Verification
The assertions check the command pipeline on every cycle. They cover the one-edge lockout after an accepted command, the hand-off of each burst address from stage to stage, the rule that at most one pair is committed per edge with the upper pair always right after the lower one, and the four-word cadence of the read sequencer. Lane masking, commit timing as seen from the read port, the rejection of data outside a burst, and independence under random concurrent traffic can only be shown by the bench's scenarios, which compare every read word against a model memory built from the requirements.

// File: rtl/qdr_b4_pkg.sv
package qdr_b4_pkg;
  localparam int unsigned LANE_W     = 9;
  localparam int unsigned BURST_LEN  = 4;
  localparam int unsigned BEAT_IDX_W = $clog2(BURST_LEN);

  typedef enum logic {
    HALF_LO = 1'b0,
    HALF_HI = 1'b1
  } half_e;
endpackage

// File: rtl/qdr_b4_wr_seq.sv
module qdr_b4_wr_seq
  import qdr_b4_pkg::*;
#(
  parameter int unsigned BADDR_W = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_n_i,
  input  logic [BADDR_W-1:0] wr_addr_i,
  output logic               cap_rise_o,
  output logic               cap_fall_o,
  output logic               commit_o,
  output half_e              commit_half_o,
  output logic [BADDR_W-1:0] commit_baddr_o
);
  // a: accepted last edge (beat0 due), b: beat2 due + low pair commit, c: high pair commit
  logic               a_vld_q, b_vld_q, c_vld_q;
  logic [BADDR_W-1:0] a_addr_q, b_addr_q, c_addr_q;
  logic               accept;

  assign accept = ~wr_n_i & ~a_vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_vld_q  <= 1'b0;
      b_vld_q  <= 1'b0;
      c_vld_q  <= 1'b0;
      a_addr_q <= '0;
      b_addr_q <= '0;
      c_addr_q <= '0;
    end else begin
      a_vld_q <= accept;
      b_vld_q <= a_vld_q;
      c_vld_q <= b_vld_q;
      if (accept)  a_addr_q <= wr_addr_i;
      if (a_vld_q) b_addr_q <= a_addr_q;
      if (b_vld_q) c_addr_q <= b_addr_q;
    end
  end

  assign cap_rise_o     = a_vld_q | b_vld_q;
  assign cap_fall_o     = b_vld_q | c_vld_q;
  assign commit_o       = b_vld_q | c_vld_q;
  assign commit_half_o  = c_vld_q ? HALF_HI : HALF_LO;
  assign commit_baddr_o = c_vld_q ? c_addr_q : b_addr_q;

  p_lockout_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    a_vld_q |=> !a_vld_q);
  p_deselect_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_n_i |=> !a_vld_q);
  p_addr_ab_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    a_vld_q |=> (b_vld_q && b_addr_q == $past(a_addr_q)));
  p_addr_bc_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    b_vld_q |=> (c_vld_q && c_addr_q == $past(b_addr_q)));
  p_one_pair_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({b_vld_q, c_vld_q}));
endmodule

// File: rtl/qdr_b4_beat_cap.sv
module qdr_b4_beat_cap #(
  parameter int unsigned DATA_W = 36,
  parameter int unsigned LANES  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_rise_i,
  input  logic              cap_fall_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [LANES-1:0]  be_n_i,
  output logic [DATA_W-1:0] even_data_o,
  output logic [LANES-1:0]  even_be_n_o,
  output logic [DATA_W-1:0] odd_data_o,
  output logic [LANES-1:0]  odd_be_n_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      even_data_o <= '0;
      even_be_n_o <= '1;
    end else if (cap_rise_i) begin
      even_data_o <= data_i;
      even_be_n_o <= be_n_i;
    end
  end

  // falling edge stands in for the complementary clock
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      odd_data_o <= '0;
      odd_be_n_o <= '1;
    end else if (cap_fall_i) begin
      odd_data_o <= data_i;
      odd_be_n_o <= be_n_i;
    end
  end
endmodule

// File: rtl/qdr_b4_array.sv
module qdr_b4_array
  import qdr_b4_pkg::*;
#(
  parameter int unsigned DATA_W = 36,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned LANES  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-2:0] wpair_i,
  input  logic [DATA_W-1:0] even_data_i,
  input  logic [LANES-1:0]  even_be_n_i,
  input  logic [DATA_W-1:0] odd_data_i,
  input  logic [LANES-1:0]  odd_be_n_i,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned WORDS = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [WORDS];
  logic [LANES-1:0]  even_we, odd_we;

  for (genvar l = 0; l < LANES; l++) begin : g_lane_we
    assign even_we[l] = we_i & ~even_be_n_i[l];
    assign odd_we[l]  = we_i & ~odd_be_n_i[l];
  end

  always_ff @(posedge clk_i) begin
    for (int l = 0; l < LANES; l++) begin
      if (even_we[l]) mem_q[{wpair_i, 1'b0}][l*LANE_W +: LANE_W] <= even_data_i[l*LANE_W +: LANE_W];
      if (odd_we[l])  mem_q[{wpair_i, 1'b1}][l*LANE_W +: LANE_W] <= odd_data_i[l*LANE_W +: LANE_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (re_i) rdata_o <= mem_q[raddr_i];
  end
endmodule

// File: rtl/qdr_b4_rd_seq.sv
module qdr_b4_rd_seq
  import qdr_b4_pkg::*;
#(
  parameter int unsigned BADDR_W = 6
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          rd_n_i,
  input  logic [BADDR_W-1:0]            rd_addr_i,
  output logic                          re_o,
  output logic [BADDR_W+BEAT_IDX_W-1:0] raddr_o,
  output logic                          vld_o
);
  logic                  act_q, vld_q;
  logic [BEAT_IDX_W-1:0] beat_q;
  logic [BADDR_W-1:0]    base_q;
  logic                  last_beat, take;

  assign last_beat = act_q & (beat_q == BEAT_IDX_W'(BURST_LEN - 1));
  assign take      = ~rd_n_i & (~act_q | last_beat);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      vld_q  <= 1'b0;
      beat_q <= '0;
      base_q <= '0;
    end else begin
      vld_q <= act_q;
      if (take) begin
        act_q  <= 1'b1;
        beat_q <= '0;
        base_q <= rd_addr_i;
      end else if (act_q) begin
        act_q  <= ~last_beat;
        beat_q <= beat_q + 1'b1;
      end
    end
  end

  assign re_o    = act_q;
  assign raddr_o = {base_q, beat_q};
  assign vld_o   = vld_q;

  p_rd_start_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_n_i && !act_q) |=> (act_q && beat_q == '0 && base_q == $past(rd_addr_i)));
  p_rd_step_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q && !last_beat) |=> (act_q && beat_q == $past(beat_q) + 1'b1 && $stable(base_q)));
  p_rd_vld_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_q |=> vld_o);
endmodule

// File: rtl/qdr_b4_sram.sv
module qdr_b4_sram
  import qdr_b4_pkg::*;
#(
  parameter int unsigned DATA_W = 36,
  parameter int unsigned ADDR_W = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_n_i,
  input  logic [ADDR_W-3:0]        wr_addr_i,
  input  logic [DATA_W-1:0]        wr_data_i,
  input  logic [DATA_W/LANE_W-1:0] wr_be_n_i,
  input  logic                     rd_n_i,
  input  logic [ADDR_W-3:0]        rd_addr_i,
  output logic [DATA_W-1:0]        rd_data_o,
  output logic                     rd_vld_o
);
  localparam int unsigned LANES   = DATA_W / LANE_W;
  localparam int unsigned BADDR_W = ADDR_W - BEAT_IDX_W;

  logic               cap_rise, cap_fall, commit;
  half_e              commit_half;
  logic [BADDR_W-1:0] commit_baddr;
  logic [DATA_W-1:0]  even_data, odd_data;
  logic [LANES-1:0]   even_be_n, odd_be_n;
  logic               re;
  logic [ADDR_W-1:0]  raddr;

  qdr_b4_wr_seq #(.BADDR_W(BADDR_W)) u_wr_seq (
    .clk_i, .rst_ni, .wr_n_i, .wr_addr_i,
    .cap_rise_o(cap_rise), .cap_fall_o(cap_fall),
    .commit_o(commit), .commit_half_o(commit_half), .commit_baddr_o(commit_baddr)
  );

  qdr_b4_beat_cap #(.DATA_W(DATA_W), .LANES(LANES)) u_beat_cap (
    .clk_i, .rst_ni, .cap_rise_i(cap_rise), .cap_fall_i(cap_fall),
    .data_i(wr_data_i), .be_n_i(wr_be_n_i),
    .even_data_o(even_data), .even_be_n_o(even_be_n),
    .odd_data_o(odd_data), .odd_be_n_o(odd_be_n)
  );

  qdr_b4_array #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .LANES(LANES)) u_array (
    .clk_i, .rst_ni, .we_i(commit), .wpair_i({commit_baddr, commit_half}),
    .even_data_i(even_data), .even_be_n_i(even_be_n),
    .odd_data_i(odd_data), .odd_be_n_i(odd_be_n),
    .re_i(re), .raddr_i(raddr), .rdata_o(rd_data_o)
  );

  qdr_b4_rd_seq #(.BADDR_W(BADDR_W)) u_rd_seq (
    .clk_i, .rst_ni, .rd_n_i, .rd_addr_i,
    .re_o(re), .raddr_o(raddr), .vld_o(rd_vld_o)
  );

  // upper pair always lands one edge after the lower pair of the same burst
  p_hi_after_lo_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit && commit_half == HALF_HI) |-> $past(commit && commit_half == HALF_LO));
  p_lo_then_hi_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit && commit_half == HALF_LO) |=> (commit && commit_half == HALF_HI && commit_baddr == $past(commit_baddr)));
endmodule

// File: tb/qdr_b4_sram_tb_top.sv
module qdr_b4_sram_tb_top;
  localparam int NCYC  = 1480;
  localparam int NSLOT = 2 * NCYC + 16;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_n_i = 1'b1;
  logic [5:0]  wr_addr_i = '0;
  logic [35:0] wr_data_i = '0;
  logic [3:0]  wr_be_n_i = '1;
  logic        rd_n_i = 1'b1;
  logic [5:0]  rd_addr_i = '0;
  logic [35:0] rd_data_o;
  logic        rd_vld_o;

  qdr_b4_sram #(.DATA_W(36), .ADDR_W(8)) dut_i (.*);

  always #4 clk_i = ~clk_i;

  logic        s_wr_n [NCYC];
  logic [5:0]  s_wa   [NCYC];
  logic        s_rd_n [NCYC];
  logic [5:0]  s_ra   [NCYC];
  logic [35:0] s_d    [NSLOT];
  logic [3:0]  s_be   [NSLOT];
  int          tg     [NCYC];
  logic        cm_v   [NCYC+4];
  int          cm_w   [NCYC+4];
  int          cm_s   [NCYC+4];
  logic [35:0] m      [256];
  logic        e_vld  [NCYC];
  logic [35:0] e_dat  [NCYC];

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  function automatic logic [35:0] merge(logic [35:0] o, logic [35:0] n, logic [3:0] be_n);
    logic [35:0] r = o;
    for (int l = 0; l < 4; l++) if (!be_n[l]) r[l*9 +: 9] = n[l*9 +: 9];
    return r;
  endfunction

  function automatic logic [35:0] rnd36();
    logic [63:0] t = {$urandom(), $urandom()};
    return t[35:0];
  endfunction

  task automatic wcmd(int c, int a);
    s_wr_n[c] = 1'b0; s_wa[c] = 6'(a);
    for (int k = 0; k < 4; k++) s_be[2*c+2+k] = 4'b0000;
  endtask

  task automatic rcmd(int c, int a);
    s_rd_n[c] = 1'b0; s_ra[c] = 6'(a);
  endtask

  task automatic build();
    for (int c = 0; c < NCYC; c++) begin
      s_wr_n[c] = 1'b1; s_rd_n[c] = 1'b1;
      s_wa[c] = 6'($urandom()); s_ra[c] = 6'($urandom());
      tg[c] = 1;
    end
    // R6: every slot carries random data and enables, used or not
    for (int s = 0; s < NSLOT; s++) begin s_d[s] = rnd36(); s_be[s] = 4'($urandom()); end
    // R5: back-to-back fill of all bursts, every second edge
    for (int k = 0; k < 64; k++) wcmd(2*k, k);
    for (int c = 0; c < 140; c++) tg[c] = 5;
    // R4: second select on the very next edge ignored
    wcmd(140, 5); s_wr_n[141] = 1'b0; s_wa[141] = 6'd6;
    // R3: mixed lane masks per beat
    wcmd(146, 7);
    s_be[294] = 4'b1010; s_be[295] = 4'b0101; s_be[296] = 4'b0000; s_be[297] = 4'b1111;
    rcmd(150, 5); rcmd(154, 6);
    for (int c = 151; c <= 158; c++) tg[c] = 4;
    rcmd(160, 7);
    for (int c = 161; c <= 165; c++) tg[c] = 3;
    // R8 and R7: read issued three edges after command, select released at once
    wcmd(170, 9); rcmd(173, 9);
    for (int c = 171; c <= 178; c++) tg[c] = 8;
    // R9: reads during a burst ignored, read on last word accepted
    rcmd(180, 3); rcmd(181, 4); rcmd(182, 4); rcmd(183, 4); rcmd(184, 10);
    for (int c = 181; c <= 190; c++) tg[c] = 9;
    // R6: data around a lone command
    wcmd(200, 11); rcmd(206, 11);
    for (int c = 201; c <= 211; c++) tg[c] = 6;
    // R2: plain burst
    wcmd(220, 12); rcmd(224, 12);
    for (int c = 221; c <= 229; c++) tg[c] = 2;
    // R10: random concurrent traffic
    for (int c = 240; c < 1200; c++) begin
      s_wr_n[c] = ($urandom() % 2) != 0;
      s_rd_n[c] = ($urandom() % 3) != 0;
      tg[c] = 10;
    end
    for (int s = 480; s < 2410; s++) s_be[s] = (($urandom() % 4) == 0) ? 4'($urandom()) : 4'b0000;
    for (int c = 1200; c < 1210; c++) tg[c] = 10;
    // R1: final readback of every burst
    for (int k = 0; k < 64; k++) rcmd(1210 + 4*k, k);
  endtask

  task automatic model();
    logic prev = 1'b0, acc, r_act = 1'b0;
    int r_beat = 0, r_base = 0;
    for (int e = 0; e < NCYC + 4; e++) cm_v[e] = 1'b0;
    for (int w = 0; w < 256; w++) m[w] = '0;
    for (int c = 0; c < NCYC; c++) begin
      acc = !s_wr_n[c] && !prev;
      prev = acc;
      if (acc) begin
        cm_v[c+2] = 1'b1; cm_w[c+2] = s_wa[c] * 4;     cm_s[c+2] = 2*c + 2;
        cm_v[c+3] = 1'b1; cm_w[c+3] = s_wa[c] * 4 + 2; cm_s[c+3] = 2*c + 4;
      end
    end
    for (int e = 0; e < NCYC; e++) begin
      logic o_act = r_act;
      int   o_beat = r_beat;
      e_vld[e] = r_act;
      e_dat[e] = r_act ? m[r_base*4 + r_beat] : '0;
      if (r_act) begin
        if (r_beat == 3) r_act = 1'b0;
        r_beat = (r_beat + 1) % 4;
      end
      if (!s_rd_n[e] && (!o_act || o_beat == 3)) begin
        r_act = 1'b1; r_beat = 0; r_base = int'(s_ra[e]);
      end
      if (cm_v[e]) begin
        m[cm_w[e]]   = merge(m[cm_w[e]],   s_d[cm_s[e]],   s_be[cm_s[e]]);
        m[cm_w[e]+1] = merge(m[cm_w[e]+1], s_d[cm_s[e]+1], s_be[cm_s[e]+1]);
      end
    end
  endtask

  task automatic drive_rise(int e);
    wr_n_i = s_wr_n[e]; wr_addr_i = s_wa[e];
    rd_n_i = s_rd_n[e]; rd_addr_i = s_ra[e];
    wr_data_i = s_d[2*e]; wr_be_n_i = s_be[2*e];
  endtask

  task automatic drive_fall(int e);
    wr_data_i = s_d[2*e+1]; wr_be_n_i = s_be[2*e+1];
  endtask

  task automatic check(int e);
    n_chk++;
    if (rd_vld_o !== e_vld[e]) begin
      n_bad++;
      $display("FAIL R%0d edge %0d rd_vld_o=%0b expected=%0b", tg[e], e, rd_vld_o, e_vld[e]);
    end else if (e_vld[e] && rd_data_o !== e_dat[e]) begin
      n_bad++;
      $display("FAIL R%0d edge %0d rd_data_o=%h expected=%h", tg[e], e, rd_data_o, e_dat[e]);
    end
  endtask

  initial begin
    void'($urandom(32'h0005eed5));
    build();
    model();
    repeat (2) @(posedge clk_i);
    @(negedge clk_i);
    #1 rst_ni = 1'b1;
    #1;
    // R11: idle read port after reset
    n_chk++;
    if (rd_vld_o !== 1'b0) begin
      n_bad++;
      $display("FAIL R11 rd_vld_o=%0b expected=0", rd_vld_o);
    end
    drive_rise(0);
    for (int e = 0; e < NCYC; e++) begin
      @(posedge clk_i); #2;
      check(e);
      drive_fall(e);
      @(negedge clk_i); #2;
      if (e + 1 < NCYC) drive_rise(e + 1);
    end
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(64'd200000 * 8);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog expired after %0d checks, expected completion", n_chk);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule